// File: doc/BRIEF.md
# Halfword and Signed-Byte Load/Store Unit

This unit carries out the narrow-data transfer instructions of a 32-bit register-file processor: halfword loads and stores, sign-extending byte and halfword loads, and the atomic register/memory swap. The pipeline offers it one instruction word with the current values of the base register, the offset register and the source register. The unit decodes the addressing fields and forms the effective address by adding or subtracting an immediate or register offset, in pre- or post-indexed form. It then drives a request/ready memory port and returns register writes for the destination and, when indexing asks for it, for the base.

A swap is recognised from a fixed bit pattern in the instruction word. It reads the addressed location and then writes the same location. A lock output stays high across both accesses so that a shared memory can keep other masters out. Each instruction ends with a one-cycle completion pulse. The register-write strobes and the two encoding-error flags are valid only in that pulse.

Top module: `hx_xfer_unit`

## Requirements
- R1: The offset is `{insn[11:8], insn[3:0]}` zero-extended when bit 22 is set, and `rm_val` when bit 22 is clear.
- R2: The computed address is `rn_val + offset` when bit 23 is 1, and `rn_val - offset` when it is 0. With bit 24 set (pre-index) the memory access uses the computed address. With bit 24 clear (post-index) it uses `rn_val`.
- R3: The base register (index `insn[19:16]`) is written with the computed address when bit 24 is 0, or when bits 24 and 21 are both 1. Otherwise it is not written. It is never written by a swap.
- R4: A load (bit 20 = 1) uses bit 6 (signed) and bit 5 (half). With 11 it sign-extends bit 15, with 10 it sign-extends bit 7, with 01 it zero-extends 16 bits, and with 00 it zero-extends 8 bits. The loaded value goes to register `insn[15:12]`. The bus size is 01 (halfword) when bit 5 is set and 00 (byte) when it is clear.
- R5: A store (bit 20 = 0) writes `rd_val[15:0]` with size 01 when bit 5 is set, or `rd_val[7:0]` with size 00 when it is clear. Upper write-data bits are zero. The destination register is not written.
- R6: A store with bit 5 set and `insn[15:12]` = 15 accesses the address 12 above the one R2 gives. The base writeback still uses the R2 address.
- R7: `err_wb_post` is 1 in the completion pulse when bit 24 is 0 and bit 21 is 1. `err_sign_store` is 1 there when bit 20 is 0 and bit 6 is 1. Both are 0 for a swap and outside the completion pulse.
- R8: An instruction with `(insn & 0x0FB00FF0) == 0x01000090` is a swap. It reads at `rn_val`, then writes at the same address, then writes the read value to register `insn[15:12]`. With bit 22 set, the size is 00, the write data is `rm_val[7:0]` and the loaded value is zero-extended. With bit 22 clear, the size is 10 (word) and the data is the full word.
- R9: `mem_lock` is high on both swap accesses and low on every other transfer. The swap write follows the read handshake with no other access in between.
- R10: Only one request is outstanding at a time, and address, data, size and write enable stay stable until `mem_ready`. `busy` is high from acceptance to completion. `start` is ignored while `busy` is high.
- R11: After reset `mem_req`, `mem_lock`, `busy`, `done`, `rd_we` and `rn_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Offer an instruction; taken when not busy |
| insn | input | 32 | Instruction word |
| rn_val | input | DW | Base register value |
| rm_val | input | DW | Offset register value / swap source |
| rd_val | input | DW | Store source register value |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 2 | 00 byte, 01 halfword, 10 word |
| mem_addr | output | DW | Byte address |
| mem_wdata | output | DW | Write data, right-aligned |
| mem_rdata | input | DW | Read data, right-aligned |
| mem_ready | input | 1 | Request completes this cycle |
| mem_lock | output | 1 | Atomic sequence in progress |
| rd_we | output | 1 | Destination register write |
| rd_idx | output | 4 | Destination register index |
| rd_data | output | DW | Destination register value |
| rn_we | output | 1 | Base register writeback |
| rn_idx | output | 4 | Base register index |
| rn_data | output | DW | Base register writeback value |
| err_wb_post | output | 1 | Writeback requested with post-indexing |
| err_sign_store | output | 1 | Signed bit set on a store |

## Verification
The assertions assume the memory raises `mem_ready` only while `mem_req` is high, and that `mem_rdata` is valid in the cycle of the ready handshake. The bench memory model decides at the falling edge whether to answer, and answers only while a request is pending. On every read it returns a full word, so upper garbage bits test the extension logic. Instruction words come from random fields, including patterns that happen to match the swap signature. The bench offers `start` only when `busy` is low, except in one directed case that checks `start` is ignored mid-instruction.

// File: rtl/hx_pkg.sv
package hx_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10
   } hx_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_ACC  = 2'b01,
      ST_SWPW = 2'b10,
      ST_FIN  = 2'b11
   } hx_state_e;

   typedef struct packed {
      logic       swap;
      logic       swp_byte;
      logic       load;
      logic       pre;
      logic       up;
      logic       wb_bit;
      logic       imm;
      logic       sgn;
      logic       half;
      logic [3:0] rd;
      logic [3:0] rn;
      logic [3:0] rm;
      logic [7:0] imm8;
   } hx_op_t;

   localparam logic [31:0] SWP_MASK  = 32'h0FB0_0FF0;
   localparam logic [31:0] SWP_MATCH = 32'h0100_0090;

endpackage

// File: rtl/hx_decode.sv
module hx_decode
   import hx_pkg::*;
(
   input  logic [31:0] insn,
   output hx_op_t      op,
   output logic        err_wbp,
   output logic        err_sst
);

   always_comb begin
      op.swap     = (insn & SWP_MASK) == SWP_MATCH;
      op.swp_byte = insn[22];
      op.load     = insn[20];
      op.pre      = insn[24];
      op.up       = insn[23];
      op.wb_bit   = insn[21];
      op.imm      = insn[22];
      op.sgn      = insn[6];
      op.half     = insn[5];
      op.rd       = insn[15:12];
      op.rn       = insn[19:16];
      op.rm       = insn[3:0];
      op.imm8     = {insn[11:8], insn[3:0]};
      err_wbp     = !op.swap && !op.pre && op.wb_bit;
      err_sst     = !op.swap && !op.load && op.sgn;
   end

endmodule

// File: rtl/hx_agen.sv
module hx_agen
   import hx_pkg::*;
#(
   parameter int DW        = 32,
   parameter int PC_IDX    = 15,
   parameter int PC_BIAS   = 12,
   parameter bit PC_ADJ_EN = 1'b1
) (
   input  hx_op_t        op,
   input  logic [DW-1:0] base,
   input  logic [DW-1:0] rmv,
   output logic [DW-1:0] acc_addr,
   output logic [DW-1:0] wb_addr,
   output logic          wb_en
);

   localparam logic [DW-1:0] BIAS = DW'(PC_BIAS);

   logic [DW-1:0] offset;
   logic [DW-1:0] calc;
   logic [DW-1:0] plain;

   always_comb begin
      offset  = op.imm ? DW'(op.imm8) : rmv;
      calc    = op.up ? base + offset : base - offset;
      plain   = (op.swap || !op.pre) ? base : calc;
      wb_addr = calc;
      wb_en   = !op.swap && (!op.pre || op.wb_bit);
   end

   generate
      if (PC_ADJ_EN) begin : g_pc_adj
         always_comb begin
            if (!op.swap && !op.load && op.half && (op.rd == 4'(PC_IDX)))
               acc_addr = plain + BIAS;
            else
               acc_addr = plain;
         end
      end else begin : g_no_adj
         always_comb acc_addr = plain;
      end
   endgenerate

endmodule

// File: rtl/hx_extend.sv
module hx_extend #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] rdata,
   input  logic          is_swap,
   input  logic          swp_byte,
   input  logic          sgn,
   input  logic          half,
   output logic [DW-1:0] value
);

   generate
      if (DW > 16) begin : g_wide
         always_comb begin
            if (is_swap)
               value = swp_byte ? {{(DW-8){1'b0}}, rdata[7:0]} : rdata;
            else begin
               unique case ({sgn, half})
                  2'b11:   value = {{(DW-16){rdata[15]}}, rdata[15:0]};
                  2'b10:   value = {{(DW-8){rdata[7]}}, rdata[7:0]};
                  2'b01:   value = {{(DW-16){1'b0}}, rdata[15:0]};
                  default: value = {{(DW-8){1'b0}}, rdata[7:0]};
               endcase
            end
         end
      end else begin : g_narrow
         always_comb begin
            if (is_swap)
               value = swp_byte ? {8'h00, rdata[7:0]} : rdata;
            else begin
               unique case ({sgn, half})
                  2'b10:   value = {{8{rdata[7]}}, rdata[7:0]};
                  2'b00:   value = {8'h00, rdata[7:0]};
                  default: value = rdata;
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/hx_xfer_unit.sv
module hx_xfer_unit
   import hx_pkg::*;
#(
   parameter int DW        = 32,
   parameter int PC_IDX    = 15,
   parameter int PC_BIAS   = 12,
   parameter bit PC_ADJ_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [31:0]   insn,
   input  logic [DW-1:0] rn_val,
   input  logic [DW-1:0] rm_val,
   input  logic [DW-1:0] rd_val,
   output logic          busy,
   output logic          done,
   output logic          mem_req,
   output logic          mem_we,
   output logic [1:0]    mem_size,
   output logic [DW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ready,
   output logic          mem_lock,
   output logic          rd_we,
   output logic [3:0]    rd_idx,
   output logic [DW-1:0] rd_data,
   output logic          rn_we,
   output logic [3:0]    rn_idx,
   output logic [DW-1:0] rn_data,
   output logic          err_wb_post,
   output logic          err_sign_store
);

   localparam logic [DW-1:0] BYTE_MASK = DW'(8'hFF);
   localparam logic [DW-1:0] HALF_MASK = DW'(16'hFFFF);

   generate
      if (DW < 16 || (DW % 8) != 0) begin : g_bad_dw
         $error("hx_xfer_unit: DW must be a multiple of 8 and at least 16");
      end
      if (PC_IDX < 0 || PC_IDX > 15) begin : g_bad_pc
         $error("hx_xfer_unit: PC_IDX must be a register index 0..15");
      end
   endgenerate

   hx_op_t        op_d, op_q;
   logic          e_wbp_d, e_sst_d, e_wbp_q, e_sst_q;
   logic [DW-1:0] acc_d, wb_d, acc_q, wb_q;
   logic          wben_d, wben_q;
   logic [DW-1:0] wdata_d, wdata_q, ext_v, rdv_q;
   hx_size_e      size_d, size_q;
   hx_state_e     state;

   hx_decode u_dec (
      .insn    (insn),
      .op      (op_d),
      .err_wbp (e_wbp_d),
      .err_sst (e_sst_d)
   );

   hx_agen #(
      .DW(DW), .PC_IDX(PC_IDX), .PC_BIAS(PC_BIAS), .PC_ADJ_EN(PC_ADJ_EN)
   ) u_agen (
      .op       (op_d),
      .base     (rn_val),
      .rmv      (rm_val),
      .acc_addr (acc_d),
      .wb_addr  (wb_d),
      .wb_en    (wben_d)
   );

   hx_extend #(.DW(DW)) u_ext (
      .rdata    (mem_rdata),
      .is_swap  (op_q.swap),
      .swp_byte (op_q.swp_byte),
      .sgn      (op_q.sgn),
      .half     (op_q.half),
      .value    (ext_v)
   );

   always_comb begin
      if (op_d.swap) begin
         size_d  = op_d.swp_byte ? SZ_BYTE : SZ_WORD;
         wdata_d = op_d.swp_byte ? (rm_val & BYTE_MASK) : rm_val;
      end else begin
         size_d  = op_d.half ? SZ_HALF : SZ_BYTE;
         wdata_d = rd_val & (op_d.half ? HALF_MASK : BYTE_MASK);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= '0;
         acc_q   <= '0;
         wb_q    <= '0;
         wben_q  <= 1'b0;
         wdata_q <= '0;
         size_q  <= SZ_BYTE;
         rdv_q   <= '0;
         e_wbp_q <= 1'b0;
         e_sst_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               op_q    <= op_d;
               acc_q   <= acc_d;
               wb_q    <= wb_d;
               wben_q  <= wben_d;
               wdata_q <= wdata_d;
               size_q  <= size_d;
               e_wbp_q <= e_wbp_d;
               e_sst_q <= e_sst_d;
               state   <= ST_ACC;
            end
            ST_ACC: if (mem_ready) begin
               rdv_q <= ext_v;
               state <= op_q.swap ? ST_SWPW : ST_FIN;
            end
            ST_SWPW: if (mem_ready) state <= ST_FIN;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy           = state != ST_IDLE;
      done           = state == ST_FIN;
      mem_req        = (state == ST_ACC) || (state == ST_SWPW);
      mem_we         = ((state == ST_ACC) && !op_q.swap && !op_q.load) || (state == ST_SWPW);
      mem_lock       = mem_req && op_q.swap;
      mem_size       = size_q;
      mem_addr       = acc_q;
      mem_wdata      = wdata_q;
      rd_we          = done && (op_q.load || op_q.swap);
      rd_idx         = op_q.rd;
      rd_data        = rdv_q;
      rn_we          = done && wben_q;
      rn_idx         = op_q.rn;
      rn_data        = wb_q;
      err_wb_post    = done && e_wbp_q;
      err_sign_store = done && e_sst_q;
   end

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata) && $stable(mem_size));

   // R10
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req && !mem_lock);

   // R9
   lock_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_lock |-> mem_req);

   // R9
   swap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ready && mem_lock && !mem_we
      |=> mem_req && mem_we && mem_lock && $stable(mem_addr));

   // R3
   rn_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rn_we |-> done);

   // R7
   err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_wb_post || err_sign_store) |-> done);

endmodule

// File: tb/hx_xfer_unit_test.sv
`timescale 1ns/1ps
module hx_xfer_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] insn = '0, rn_val = '0, rm_val = '0, rd_val = '0;
   logic        busy, done, mem_req, mem_we, mem_lock;
   logic [1:0]  mem_size;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_ready = 1'b0;
   logic        rd_we, rn_we, err_wb_post, err_sign_store;
   logic [3:0]  rd_idx, rn_idx;
   logic [31:0] rd_data, rn_data;

   always #2 clk = ~clk;

   hx_xfer_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
      .rn_val(rn_val), .rm_val(rm_val), .rd_val(rd_val),
      .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
      .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_lock(mem_lock),
      .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
      .rn_we(rn_we), .rn_idx(rn_idx), .rn_data(rn_data),
      .err_wb_post(err_wb_post), .err_sign_store(err_sign_store)
   );

   // behavioural byte memory, little-endian, 256 bytes with wrap
   logic [7:0] mem [256];

   function automatic logic [31:0] rdw(input logic [31:0] a);
      logic [7:0] b;
      b = a[7:0];
      return {mem[8'(b + 8'd3)], mem[8'(b + 8'd2)], mem[8'(b + 8'd1)], mem[b]};
   endfunction

   always_comb mem_rdata = rdw(mem_addr);

   always @(negedge clk) mem_ready <= mem_req && ($urandom_range(0, 2) != 0);

   // transaction log
   int          lg_n = 0;
   logic [31:0] lg_addr  [16];
   logic [31:0] lg_wdata [16];
   logic        lg_we    [16];
   logic        lg_lock  [16];
   logic [1:0]  lg_size  [16];

   always @(posedge clk) begin
      if (mem_req && mem_ready) begin
         lg_addr[lg_n % 16]  <= mem_addr;
         lg_wdata[lg_n % 16] <= mem_wdata;
         lg_we[lg_n % 16]    <= mem_we;
         lg_lock[lg_n % 16]  <= mem_lock;
         lg_size[lg_n % 16]  <= mem_size;
         lg_n <= lg_n + 1;
         if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata[7:0];
            if (mem_size != 2'b00) mem[8'(mem_addr[7:0] + 8'd1)] <= mem_wdata[15:8];
            if (mem_size == 2'b10) begin
               mem[8'(mem_addr[7:0] + 8'd2)] <= mem_wdata[23:16];
               mem[8'(mem_addr[7:0] + 8'd3)] <= mem_wdata[31:24];
            end
         end
      end
   end

   int nchk = 0, nfail = 0, cyc = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         nfail++;
         $display("FAIL R10 watchdog expired actual=%0d expected<%0d", cyc, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   // expected values
   int          e_n;
   logic [31:0] e_addr [2];
   logic [31:0] e_wdata[2];
   logic        e_we   [2];
   logic        e_lock [2];
   logic [1:0]  e_size [2];
   logic        e_rd_we, e_rn_we, e_ewp, e_ess;
   logic [31:0] e_rd_data, e_rn_data;

   task automatic expect_op(input logic [31:0] i, input logic [31:0] rn, input logic [31:0] rm,
                            input logic [31:0] rd);
      logic [31:0] off, calc, acc, old;
      e_rn_we = 1'b0; e_rn_data = '0; e_ewp = 1'b0; e_ess = 1'b0;
      if ((i & 32'h0FB0_0FF0) == 32'h0100_0090) begin
         old = rdw(rn);
         e_n = 2;
         e_addr[0] = rn; e_addr[1] = rn;
         e_we[0] = 1'b0; e_we[1] = 1'b1;
         e_lock[0] = 1'b1; e_lock[1] = 1'b1;
         e_size[0] = i[22] ? 2'b00 : 2'b10; e_size[1] = e_size[0];
         e_wdata[0] = '0;
         e_wdata[1] = i[22] ? {24'h0, rm[7:0]} : rm;
         e_rd_we = 1'b1;
         e_rd_data = i[22] ? {24'h0, old[7:0]} : old;
      end else begin
         off  = i[22] ? {24'h0, i[11:8], i[3:0]} : rm;
         calc = i[23] ? rn + off : rn - off;
         acc  = i[24] ? calc : rn;
         if (!i[20] && i[5] && i[15:12] == 4'd15) acc = acc + 32'd12;
         old = rdw(acc);
         e_n = 1;
         e_addr[0] = acc; e_we[0] = !i[20]; e_lock[0] = 1'b0;
         e_size[0] = i[5] ? 2'b01 : 2'b00;
         e_wdata[0] = i[5] ? {16'h0, rd[15:0]} : {24'h0, rd[7:0]};
         e_rd_we = i[20];
         case ({i[6], i[5]})
            2'b11:   e_rd_data = {{16{old[15]}}, old[15:0]};
            2'b10:   e_rd_data = {{24{old[7]}}, old[7:0]};
            2'b01:   e_rd_data = {16'h0, old[15:0]};
            default: e_rd_data = {24'h0, old[7:0]};
         endcase
         e_rn_we = !i[24] || i[21];
         e_rn_data = calc;
         e_ewp = !i[24] && i[21];
         e_ess = !i[20] && i[6];
      end
   endtask

   task automatic run_op(input logic [31:0] i, input logic [31:0] rn, input logic [31:0] rm,
                         input logic [31:0] rd, input bit poke_busy);
      int base, k;
      expect_op(i, rn, rm, rd);
      base = lg_n;
      @(negedge clk);
      insn = i; rn_val = rn; rm_val = rm; rd_val = rd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke_busy) begin
         // R10: start offered mid-instruction must be ignored
         insn = 32'h0140_0091; rn_val = 32'h40; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      k = 0;
      while (!done && k < 200) begin
         @(negedge clk);
         k++;
      end
      chk("R10 completion", 32'(done), 32'd1);
      chk("R9 access count", 32'(lg_n - base), 32'(e_n));
      for (int t = 0; t < e_n; t++) begin
         chk("R2 address", lg_addr[(base + t) % 16], e_addr[t]);
         chk("R5 write enable", 32'(lg_we[(base + t) % 16]), 32'(e_we[t]));
         chk("R4 size", 32'(lg_size[(base + t) % 16]), 32'(e_size[t]));
         chk("R9 lock", 32'(lg_lock[(base + t) % 16]), 32'(e_lock[t]));
         if (e_we[t]) chk("R5 write data", lg_wdata[(base + t) % 16], e_wdata[t]);
      end
      chk("R4 rd write", 32'(rd_we), 32'(e_rd_we));
      if (e_rd_we) begin
         chk("R4 rd data", rd_data, e_rd_data);
         chk("R8 rd index", 32'(rd_idx), 32'(i[15:12]));
      end
      chk("R3 rn write", 32'(rn_we), 32'(e_rn_we));
      if (e_rn_we) begin
         chk("R3 rn data", rn_data, e_rn_data);
         chk("R3 rn index", 32'(rn_idx), 32'(i[19:16]));
      end
      chk("R7 wb/post", 32'(err_wb_post), 32'(e_ewp));
      chk("R7 signed store", 32'(err_sign_store), 32'(e_ess));
      @(negedge clk);
      chk("R7 flags only in pulse", 32'({err_wb_post, err_sign_store, done}), 32'd0);
      if (poke_busy) begin
         repeat (4) @(negedge clk);
         chk("R10 ignored start", 32'(lg_n - base), 32'(e_n));
         chk("R10 idle after", 32'(busy), 32'd0);
      end
   endtask

   function automatic logic [31:0] mk_xfer(input bit p, u, im, w, l, s, h,
                                           input logic [3:0] rn, rd, hi, lo);
      return {4'hE, 3'b000, p, u, im, w, l, rn, rd, hi, 1'b1, s, h, 1'b1, lo};
   endfunction

   function automatic logic [31:0] mk_swap(input bit b, input logic [3:0] rn, rd, rm);
      return {4'hE, 5'b00010, b, 2'b00, rn, rd, 8'h09, rm};
   endfunction

   initial begin
      process::self().srandom(32'd7321);
      for (int a = 0; a < 256; a++) mem[a] = 8'($urandom);
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 reset outputs", 32'({mem_req, mem_lock, busy, done, rd_we, rn_we}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 idle after reset", 32'({mem_req, busy, done}), 32'd0);

      // R1 split immediate 0xA5, pre-index add, unsigned halfword load
      run_op(mk_xfer(1, 1, 1, 0, 1, 0, 1, 4'd2, 4'd3, 4'hA, 4'h5), 32'h1000_0010, 32'hFFFF, 0, 0);
      // R2 register offset, subtract, pre-index with writeback
      run_op(mk_xfer(1, 0, 0, 1, 1, 1, 1, 4'd4, 4'd5, 4'h0, 4'd6), 32'h80, 32'h21, 0, 0);
      // R4 signed byte load of 0x80
      mem[8'h30] = 8'h80;
      run_op(mk_xfer(1, 1, 1, 0, 1, 1, 0, 4'd1, 4'd7, 4'h0, 4'h0), 32'h30, 0, 0, 0);
      // R4 signed halfword load of 0x8001
      mem[8'h40] = 8'h01; mem[8'h41] = 8'h80;
      run_op(mk_xfer(1, 1, 1, 0, 1, 1, 1, 4'd1, 4'd7, 4'h0, 4'h0), 32'h40, 0, 0, 0);
      // R3 R7 post-index with W set
      run_op(mk_xfer(0, 1, 1, 1, 1, 0, 1, 4'd8, 4'd9, 4'h1, 4'h0), 32'h50, 0, 0, 0);
      // R6 halfword store from R15
      run_op(mk_xfer(1, 1, 1, 0, 0, 0, 1, 4'd2, 4'd15, 4'h0, 4'h4), 32'h60, 0, 32'hCAFE_1234, 0);
      // R7 signed store, R5 byte store
      run_op(mk_xfer(1, 1, 1, 0, 0, 1, 0, 4'd2, 4'd3, 4'h0, 4'h1), 32'h70, 0, 32'h1234_56AB, 0);
      // R8 R9 byte swap and word swap
      run_op(mk_swap(1'b1, 4'd1, 4'd2, 4'd3), 32'h90, 32'hDEAD_BE5A, 0, 0);
      run_op(mk_swap(1'b0, 4'd1, 4'd2, 4'd3), 32'hA0, 32'h0BAD_F00D, 0, 0);
      // R10 start while busy
      run_op(mk_xfer(1, 1, 1, 0, 1, 0, 1, 4'd2, 4'd3, 4'h0, 4'h2), 32'hB0, 0, 0, 1);

      for (int n = 0; n < 400; n++) begin
         logic [31:0] i;
         if ($urandom_range(0, 3) == 0)
            i = mk_swap(1'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
         else
            i = mk_xfer(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                        1'($urandom), 1'($urandom), 1'($urandom),
                        4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
         run_op(i, $urandom, ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 300)) : $urandom,
                $urandom, 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule